// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block sits on the controller side of a serial audio link. It runs on the bit clock it receives and turns a set of parallel slot payloads into a continuous stream of 256-bit frames. Each frame begins with a 16-bit tag word that says which of the following slots carry real data. Twelve 20-bit data slots follow it. A frame marker line is high for the whole tag word and low for all the data slots.

User logic presents twelve 20-bit payloads, a 12-bit mask of valid slots and a frame-valid flag. The block copies them into a holding register on the clock edge that launches a new frame and raises a one-cycle strobe in that same cycle. The user logic may then prepare the next frame. Any slot whose mask bit is clear goes out as zeros, whatever its payload holds.

Top module: `acl_out_serializer`

## Requirements
- R1: One frame lasts 256 clock cycles. `frame_start_o` is high for exactly one cycle per frame, and that cycle is the one in which the first tag bit is on `sdo_o`. All outputs are registered and change only on the rising clock edge.
- R2: Within a frame the serial order is the 16-bit tag word first, then slots 1 to 12 of 20 bits each. Every word is sent most significant bit first.
- R3: `sync_o` is high during the 16 tag-bit cycles of every frame and low during the other 240 cycles.
- R4: Tag bit 15 carries `frame_vld_i`. Tag bit 15-n carries `slot_valid_i[n-1]`, which is the valid flag of slot n, for n from 1 to 12. Tag bits 2 to 0 are always 0.
- R5: A slot whose `slot_valid_i` bit is 0 is sent as twenty 0 bits, whatever its payload holds.
- R6: The payload of a valid slot n is `slot_data_i[(n-1)*20 +: 20]`, sent bit 19 first.
- R7: All inputs are sampled on the rising edge that launches tag bit 15. Later changes to the inputs do not alter the frame that is being sent, and they appear in the next frame.
- R8: While `rst` is high, `sync_o`, `sdo_o` and `frame_start_o` are low from the next clock edge on. The first rising edge after `rst` falls starts a new frame at tag bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld_i | input | 1 | Frame-valid flag, sent as tag bit 15 |
| slot_valid_i | input | 12 | Valid mask; bit n-1 belongs to slot n |
| slot_data_i | input | 240 | Payloads; slot n sits at bits (n-1)*20 +: 20 |
| sync_o | output | 1 | Frame marker, high during the tag word |
| sdo_o | output | 1 | Serial data out |
| frame_start_o | output | 1 | One-cycle strobe: inputs were captured and the frame has begun |

## Verification
Two events can fall in the same cycle: the block capturing the payload at the frame boundary, and the user logic updating that payload. The bench provokes this by changing the inputs in the last bit cycle of a frame, just before the capturing edge. It expects the new values in the frame that follows. It also changes the inputs in the strobe cycle, just after the capturing edge, and expects the frame in flight to keep the old values and the next frame to carry the new ones. In every case each bit of the frame is compared against a model built from the tag and slot rules.

// File: rtl/acl_pkg.sv
package acl_pkg;
    localparam int SLOTS      = 12;
    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int FRAME_LEN  = TAG_W + SLOTS * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_LEN);
    localparam int SLOT_IDX_W = $clog2(SLOTS + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_W);

    typedef struct packed {
        logic                          frame_ok;
        logic [SLOTS-1:0]              valid;
        logic [SLOTS-1:0][SLOT_W-1:0]  data;
    } frame_t;

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] slot;   // 0 = tag word
        logic [BIT_IDX_W-1:0]  bitn;   // counts down to 0
        logic [CNT_W-1:0]      pos;    // linear position in frame
    } cursor_t;

    function automatic logic [TAG_W-1:0] build_tag(frame_t f);
        logic [TAG_W-1:0] t;
        t = '0;
        t[TAG_W-1] = f.frame_ok;
        for (int i = 0; i < SLOTS; i++) begin
            t[TAG_W-2-i] = f.valid[i];
        end
        return t;
    endfunction
endpackage

// File: rtl/acl_frame_cursor.sv
module acl_frame_cursor
    import acl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output cursor_t cur,
    output logic    at_start
);
    localparam logic [BIT_IDX_W-1:0]  TAG_TOP  = BIT_IDX_W'(TAG_W - 1);
    localparam logic [BIT_IDX_W-1:0]  SLOT_TOP = BIT_IDX_W'(SLOT_W - 1);
    localparam logic [SLOT_IDX_W-1:0] LAST_SL  = SLOT_IDX_W'(SLOTS);
    localparam logic [CNT_W-1:0]      LAST_POS = CNT_W'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.slot <= '0;
            cur.bitn <= TAG_TOP;
            cur.pos  <= '0;
        end else begin
            cur.pos <= (cur.pos == LAST_POS) ? '0 : cur.pos + 1'b1;
            if (cur.bitn == '0) begin
                if (cur.slot == LAST_SL) begin
                    cur.slot <= '0;
                    cur.bitn <= TAG_TOP;
                end else begin
                    cur.slot <= cur.slot + 1'b1;
                    cur.bitn <= SLOT_TOP;
                end
            end else begin
                cur.bitn <= cur.bitn - 1'b1;
            end
        end
    end

    assign at_start = (cur.pos == '0);

    // R1
    pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.pos == LAST_POS) |=> (cur.pos == '0 && cur.slot == '0));
    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur.slot <= LAST_SL);
    // R3
    tag_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.slot == '0) |-> (cur.pos < CNT_W'(TAG_W)));
endmodule

// File: rtl/acl_shadow.sv
module acl_shadow
    import acl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t live,
    output frame_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= live;
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held));
endmodule

// File: rtl/acl_bit_pick.sv
module acl_bit_pick
    import acl_pkg::*;
(
    input  frame_t  f,
    input  cursor_t cur,
    output logic    bit_o
);
    logic [SLOTS:0][SLOT_W-1:0] lane;

    assign lane[0] = SLOT_W'(build_tag(f));

    for (genvar s = 1; s <= SLOTS; s++) begin : g_lane
        assign lane[s] = f.valid[s-1] ? f.data[s-1] : '0;
    end

    assign bit_o = lane[cur.slot][cur.bitn];
endmodule

// File: rtl/acl_out_serializer.sv
module acl_out_serializer
    import acl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_vld_i,
    input  logic [SLOTS-1:0]         slot_valid_i,
    input  logic [SLOTS*SLOT_W-1:0]  slot_data_i,
    output logic                     sync_o,
    output logic                     sdo_o,
    output logic                     frame_start_o
);
    cursor_t                cur;
    logic                   at_start;
    frame_t                 live, held, view;
    logic                   next_bit;
    logic [SLOT_IDX_W-1:0]  slot_q;

    always_comb begin
        live.frame_ok = frame_vld_i;
        live.valid    = slot_valid_i;
        for (int s = 0; s < SLOTS; s++) begin
            live.data[s] = slot_data_i[s*SLOT_W +: SLOT_W];
        end
    end

    acl_frame_cursor u_cursor (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .at_start (at_start)
    );

    acl_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .load (at_start),
        .live (live),
        .held (held)
    );

    // the first tag bit leaves in the capture cycle, so it bypasses the shadow
    assign view = at_start ? live : held;

    acl_bit_pick u_pick (
        .f     (view),
        .cur   (cur),
        .bit_o (next_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_o        <= 1'b0;
            sdo_o         <= 1'b0;
            frame_start_o <= 1'b0;
            slot_q        <= '0;
        end else begin
            sync_o        <= (cur.slot == '0);
            sdo_o         <= next_bit;
            frame_start_o <= at_start;
            slot_q        <= cur.slot;
        end
    end

    logic [SLOT_IDX_W-1:0] slot_lane;
    assign slot_lane = slot_q - 1'b1;

    // R1
    fs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);
    // R3
    sync_start_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> sync_o);
    // R3
    sync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(sync_o)) |-> (slot_q == SLOT_IDX_W'(1)));
    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && slot_q != '0 && !held.valid[slot_lane]) |-> !sdo_o);
    // R8
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!sync_o && !sdo_o && !frame_start_o));
endmodule

// File: tb/acl_out_serializer_tb_top.sv
module acl_out_serializer_tb_top;
    localparam int NS = 12;
    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fv  = 1'b0;
    logic [NS-1:0] vmask = '0;
    logic [NS*SW-1:0] data = '0;
    logic          sync_o, sdo_o, frame_start_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    acl_out_serializer dut_i (
        .clk           (clk),
        .rst           (rst),
        .frame_vld_i   (fv),
        .slot_valid_i  (vmask),
        .slot_data_i   (data),
        .sync_o        (sync_o),
        .sdo_o         (sdo_o),
        .frame_start_o (frame_start_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NS*SW-1:0] pattern(int seed);
        logic [NS*SW-1:0] d;
        for (int s = 0; s < NS; s++) begin
            d[s*SW +: SW] = SW'((s + 1) * 32'h1111 ^ seed);
        end
        return d;
    endfunction

    function automatic logic exp_bit(int pos, logic f, logic [NS-1:0] v, logic [NS*SW-1:0] d);
        int b, off, s, k;
        if (pos < 16) begin
            b = 15 - pos;
            if (b == 15) return f;
            if (b >= 3) return v[14-b];
            return 1'b0;
        end
        off = pos - 16;
        s = off / SW;
        k = SW - 1 - (off % SW);
        return v[s] ? d[s*SW + k] : 1'b0;
    endfunction

    // called at the negedge where frame_start_o is high (position 0)
    task automatic check_frame(string req, logic f, logic [NS-1:0] v, logic [NS*SW-1:0] d);
        int bad_d = 0, bad_s = 0, first = -1;
        for (int p = 0; p < 256; p++) begin
            if (p > 0) @(negedge clk);
            if (sdo_o !== exp_bit(p, f, v, d)) begin
                bad_d++;
                if (first < 0) first = p;
            end
            if (sync_o !== (p < 16)) bad_s++;
            if (p > 0 && frame_start_o !== 1'b0) bad_s++;
        end
        chk(bad_d == 0, req, "data bits wrong (count; first at pos)", bad_d * 1000 + first, 0);
        chk(bad_s == 0, "R3", "sync/strobe bits wrong", bad_s, 0);
    endtask

    task automatic wait_fs(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (frame_start_o !== 1'b1 && cycles < 1000);
    endtask

    task automatic test_reset();
        int c;
        rst = 1'b1;
        fv = 1'b1; vmask = 12'hFFF; data = pattern(32'h0A5A5);
        repeat (3) @(negedge clk);
        chk({sync_o, sdo_o, frame_start_o} == 3'b000, "R8", "outputs in reset", {sync_o, sdo_o, frame_start_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_start_o == 1'b1 && sync_o == 1'b1, "R8", "frame start after release", {frame_start_o, sync_o}, 3);
        check_frame("R6", fv, vmask, data);
        wait_fs(c);
        chk(c == 1, "R1", "frame length tail", c, 1);
    endtask

    task automatic test_sparse();
        int c;
        fv = 1'b0; vmask = 12'b1010_0110_0010; data = '1;
        wait_fs(c);
        chk(c == 256, "R1", "frame period", c, 256);
        check_frame("R5", fv, vmask, data);
        fv = 1'b1; vmask = 12'b0101_1001_1101; data = pattern(32'h3C3C7);
        wait_fs(c);
        check_frame("R4", fv, vmask, data);
    endtask

    task automatic test_midframe_change();
        int c;
        logic [NS*SW-1:0] old_d;
        logic [NS-1:0] old_v;
        logic old_f;
        old_f = 1'b1; old_v = 12'hF0F; old_d = pattern(32'h12345);
        fv = old_f; vmask = old_v; data = old_d;
        wait_fs(c);
        // at the strobe cycle, after capture
        fv = 1'b0; vmask = 12'h0F0; data = pattern(32'h55AA5);
        check_frame("R7", old_f, old_v, old_d);
        wait_fs(c);
        chk(c == 1, "R1", "back-to-back frames", c, 1);
        check_frame("R7", fv, vmask, data);
    endtask

    task automatic test_boundary_update();
        int c;
        wait_fs(c);
        repeat (255) @(negedge clk);
        // last bit cycle: change lands on the capturing edge
        fv = 1'b1; vmask = 12'h5A5; data = pattern(32'h7E7E1);
        @(negedge clk);
        chk(frame_start_o == 1'b1, "R1", "strobe at 256", frame_start_o, 1);
        check_frame("R7", fv, vmask, data);
        vmask = 12'h000; fv = 1'b0; data = '1;
        wait_fs(c);
        check_frame("R5", fv, vmask, data);
    endtask

    task automatic test_reset_midframe();
        int c;
        wait_fs(c);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({sync_o, sdo_o, frame_start_o} == 3'b000, "R8", "outputs after mid-frame reset", {sync_o, sdo_o, frame_start_o}, 0);
        repeat (2) @(negedge clk);
        fv = 1'b1; vmask = 12'hFFF; data = pattern(32'h0BEEF);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_start_o == 1'b1, "R8", "restart at tag bit", frame_start_o, 1);
        check_frame("R2", fv, vmask, data);
    endtask

    initial begin
        test_reset();
        test_sparse();
        test_midframe_change();
        test_boundary_update();
        test_reset_midframe();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule